// File: doc/BRIEF.md
# Piecewise-Binned Pixel Histogram with Statistics Line Output

This block builds a 244-bin histogram of 20-bit pixel codes across one frame. The bins are not all the same width. The low code range uses narrow bins, the middle range uses medium bins and the top range uses wide bins. This gives fine resolution in the dark codes and still covers the full 20-bit span. A downstream exposure controller reads the resulting statistics.

A frame-end pulse freezes the bin counts into a snapshot. On the next cycle the block begins streaming a statistics line of 12-bit words, one word per cycle. The line holds a tag, a word count, the frame count, the frame ID and every bin count. All 10-bit payloads sit in the upper ten bits of each word. Because the counts are snapshotted, the live counters can start on the next frame while the line is still streaming.

Top module: `hist_stats_engine`

## Requirements
- R1: After reset, `stat_valid_o` is 0 and `stat_data_o` is 0, and every bin count is 0.
- R2: A counted code c below 4096 increments bin c/64, which is one of bins 0 to 63.
- R3: A counted code c from 4096 to 65535 increments bin 64 + (c-4096)/512, which is one of bins 64 to 183.
- R4: A counted code c from 65536 to 1048575 increments bin 184 + (c-65536)/16384, which is one of bins 184 to 243.
- R5: A pixel is counted only in a cycle where `pix_valid_i` is 1. In any other cycle the pixel has no effect.
- R6: When `frame_start_i` is high, all bins are cleared. A valid pixel in that same cycle becomes the first count of the new frame.
- R7: An accepted `frame_end_i` snapshots the counts, and a valid pixel in that same cycle is included in the snapshot. The line starts on the next cycle, with `stat_valid_o` high for 494 consecutive cycles. Outside a line, `stat_valid_o` is 0 and `stat_data_o` is 0.
- R8: The line opens with six words in this order:
  - 12'h0B0
  - {10'd492, 2'b00}
  - frame count bits [15:8]
  - frame count bits [7:0]
  - frame ID bits [15:8]
  - frame ID bits [7:0]

  Each of the last four is sent as {2'b00, byte, 2'b00}. The frame count and frame ID are taken as they were in the frame-end cycle.
- R9: After the six header words come the 244 bins, in order from bin 0 to bin 243. Each bin sends two words: first {count[19:10], 2'b00}, then {count[9:0], 2'b00}. The count is zero-extended to 20 bits.
- R10: A bin count stops at 2^CNT_W-1 and does not wrap. CNT_W defaults to 20.
- R11: A `frame_end_i` pulse that arrives while a line is being sent is ignored. The running line continues unchanged.
- R12: Pixels keep being counted while a line is being sent, and they do not change the words of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_i | input | 20 | Pixel code |
| pix_valid_i | input | 1 | Pixel qualifier |
| frame_start_i | input | 1 | Clears all bins |
| frame_end_i | input | 1 | Snapshots the bins and starts the statistics line |
| frame_count_i | input | ID_W | Frame counter value |
| frame_id_i | input | ID_W | Frame identifier |
| stat_data_o | output | 12 | Statistics word |
| stat_valid_o | output | 1 | Statistics word valid |

## Verification
A pixel that is accepted at a clock edge shows up only in a later line. It lands in the snapshot taken at the next accepted frame end, and its bin word appears 7+2·bin and 8+2·bin cycles after that edge. The tag is due one cycle after the accepted frame-end edge, and word k is due k+1 cycles after it. The bench drives its inputs just after each rising edge and samples 1 time unit after the following edge. It compares every cycle against a queue of expected words. The bench model fills that queue when it decides that a frame end is accepted, which happens only when the previous cycle showed no valid word.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int PIX_W     = 20;
  localparam int WORD_W    = 12;
  localparam int PAY_W     = 10;
  // piecewise range edges and bin shifts
  localparam int R0_END    = 4096;
  localparam int R0_SH     = 6;
  localparam int R1_END    = 65536;
  localparam int R1_SH     = 9;
  localparam int R2_SH     = 14;
  localparam int R0_BINS   = R0_END >> R0_SH;
  localparam int R1_BINS   = (R1_END - R0_END) >> R1_SH;
  localparam int R2_BINS   = ((1 << PIX_W) - R1_END) >> R2_SH;
  localparam int NUM_BINS  = R0_BINS + R1_BINS + R2_BINS;
  localparam int BIN_W     = $clog2(NUM_BINS);
  localparam int HDR_WORDS = 6;
  localparam int LINE_WORDS = HDR_WORDS + 2 * NUM_BINS;
  localparam int WORD_CNT  = LINE_WORDS - 2;
  localparam logic [WORD_W-1:0] STAT_TAG = 12'h0B0;

  function automatic logic [BIN_W-1:0] bin_of(input logic [PIX_W-1:0] c);
    logic [PIX_W-1:0] t;
    if (c < PIX_W'(R0_END))
      t = c >> R0_SH;
    else if (c < PIX_W'(R1_END))
      t = PIX_W'(R0_BINS) + ((c - PIX_W'(R0_END)) >> R1_SH);
    else
      t = PIX_W'(R0_BINS + R1_BINS) + ((c - PIX_W'(R1_END)) >> R2_SH);
    return t[BIN_W-1:0];
  endfunction
endpackage

// File: rtl/hist_bin_map.sv
module hist_bin_map
  import hist_pkg::*;
(
  input  logic [PIX_W-1:0]    pix_i,
  input  logic                valid_i,
  output logic [NUM_BINS-1:0] hit_o
);
  logic [BIN_W-1:0] bin_idx;
  assign bin_idx = bin_of(pix_i);

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_hit
    assign hit_o[b] = valid_i && (bin_idx == BIN_W'(b));
  end
endmodule

// File: rtl/hist_counter_bank.sv
module hist_counter_bank
  import hist_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_BINS-1:0]             hit_i,
  input  logic                            clear_i,
  input  logic                            snap_i,
  output logic [NUM_BINS-1:0][CNT_W-1:0]  snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
      if (clear_i)
        cnt_nxt = hit_i[b] ? CNT_W'(1) : '0;
      else if (hit_i[b] && cnt_q != CNT_MAX)
        cnt_nxt = cnt_q + CNT_W'(1);
      else
        cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q     <= '0;
        snap_o[b] <= '0;
      end else begin
        cnt_q <= cnt_nxt;
        if (snap_i) snap_o[b] <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/hist_line_serializer.sv
module hist_line_serializer
  import hist_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int ID_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_BINS-1:0][CNT_W-1:0] cnts_i,
  input  logic [ID_W-1:0]                frame_count_i,
  input  logic [ID_W-1:0]                frame_id_i,
  output logic                           busy_o,
  output logic [WORD_W-1:0]              data_o
);
  localparam int IDX_W = $clog2(LINE_WORDS);
  localparam int HALF  = ID_W / 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_WORDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [ID_W-1:0]  fc_q, fid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      fc_q   <= '0;
      fid_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      fc_q   <= frame_count_i;
      fid_q  <= frame_id_i;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + IDX_W'(1);
    end
  end

  logic [IDX_W-1:0] off;
  logic [BIN_W-1:0] bin_sel;
  logic [19:0]      cnt_ext;
  logic [PAY_W-1:0] pay;

  always_comb begin
    off     = idx_q - IDX_W'(HDR_WORDS);
    bin_sel = BIN_W'(off[IDX_W-1:1]);
    cnt_ext = 20'(cnts_i[bin_sel]);
    case (idx_q)
      IDX_W'(1): pay = PAY_W'(WORD_CNT);
      IDX_W'(2): pay = PAY_W'(fc_q[ID_W-1:HALF]);
      IDX_W'(3): pay = PAY_W'(fc_q[HALF-1:0]);
      IDX_W'(4): pay = PAY_W'(fid_q[ID_W-1:HALF]);
      IDX_W'(5): pay = PAY_W'(fid_q[HALF-1:0]);
      default:   pay = off[0] ? cnt_ext[9:0] : cnt_ext[19:10];
    endcase
    if (!busy_q)             data_o = '0;
    else if (idx_q == '0)    data_o = STAT_TAG;
    else                     data_o = {pay, 2'b00};
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/hist_stats_engine.sv
module hist_stats_engine
  import hist_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int ID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [19:0]       pix_i,
  input  logic              pix_valid_i,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic [ID_W-1:0]   frame_count_i,
  input  logic [ID_W-1:0]   frame_id_i,
  output logic [11:0]       stat_data_o,
  output logic              stat_valid_o
);
  logic [NUM_BINS-1:0]            hit;
  logic [NUM_BINS-1:0][CNT_W-1:0] snap;
  logic                           busy;
  logic                           accept;

  assign accept = frame_end_i && !busy;

  hist_bin_map u_map (
    .pix_i   (pix_i),
    .valid_i (pix_valid_i),
    .hit_o   (hit)
  );

  hist_counter_bank #(.CNT_W(CNT_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .clear_i (frame_start_i),
    .snap_i  (accept),
    .snap_o  (snap)
  );

  hist_line_serializer #(.CNT_W(CNT_W), .ID_W(ID_W)) u_ser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (frame_end_i),
    .cnts_i        (snap),
    .frame_count_i (frame_count_i),
    .frame_id_i    (frame_id_i),
    .busy_o        (busy),
    .data_o        (stat_data_o)
  );

  assign stat_valid_o = busy;
endmodule

// File: rtl/hist_stats_chk.sv
module hist_stats_chk
  import hist_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_end_i,
  input logic [11:0] stat_data_o,
  input logic        stat_valid_o
);
  logic [9:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (stat_valid_o) run_q <= run_q + 10'd1;
    else                   run_q <= '0;
  end

  // R7
  start_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_valid_o) |-> $past(frame_end_i));

  // R7
  line_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_valid_o) |-> run_q == 10'(LINE_WORDS));

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_valid_o |-> stat_data_o == '0);

  // R8
  tag_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_valid_o) |-> stat_data_o == STAT_TAG);

  // R8
  count_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && run_q == 10'd1) |-> stat_data_o == {10'(WORD_CNT), 2'b00});

  // R9
  pad_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> stat_data_o[1:0] == 2'b00);
endmodule

bind hist_stats_engine hist_stats_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_end_i  (frame_end_i),
  .stat_data_o  (stat_data_o),
  .stat_valid_o (stat_valid_o)
);

// File: tb/sim_hist_stats_engine.sv
module sim_hist_stats_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 11;
  localparam int SAT = (1 << CNT_W) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] pix_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic        frame_end_i = 1'b0;
  logic [15:0] frame_count_i = '0;
  logic [15:0] frame_id_i = '0;
  logic [11:0] stat_data_o;
  logic        stat_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int cnt [244];
  int exp_q[$];
  string lbl_q[$];
  bit cur_valid = 0;
  string phase = "R1";
  int seed = 7;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hist_stats_engine #(.CNT_W(CNT_W), .ID_W(16)) u0 (.*);

  function automatic int ref_bin(int c);
    if (c < 4096)  return c / 64;
    if (c < 65536) return 64 + (c - 4096) / 512;
    return 184 + (c - 65536) / 16384;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (%s): actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  task automatic push_line(string blbl);
    exp_q.push_back(12'h0B0);                       lbl_q.push_back("R8");
    exp_q.push_back(492 << 2);                      lbl_q.push_back("R8");
    exp_q.push_back(int'(frame_count_i[15:8]) << 2); lbl_q.push_back("R8");
    exp_q.push_back(int'(frame_count_i[7:0]) << 2);  lbl_q.push_back("R8");
    exp_q.push_back(int'(frame_id_i[15:8]) << 2);    lbl_q.push_back("R8");
    exp_q.push_back(int'(frame_id_i[7:0]) << 2);     lbl_q.push_back("R8");
    for (int b = 0; b < 244; b++) begin
      string l = (cnt[b] == SAT) ? "R10" : blbl;
      exp_q.push_back(((cnt[b] >> 10) & 'h3FF) << 2); lbl_q.push_back(l);
      exp_q.push_back((cnt[b] & 'h3FF) << 2);         lbl_q.push_back(l);
    end
  endtask

  // one clock: drive, model, edge, compare
  task automatic step(bit pv, int px, bit fs, bit fe, string blbl);
    pix_valid_i = pv; pix_i = 20'(px);
    frame_start_i = fs; frame_end_i = fe;
    if (fs) foreach (cnt[b]) cnt[b] = 0;
    if (pv) begin
      int b = ref_bin(px);
      if (cnt[b] < SAT) cnt[b]++;
    end
    if (fe && !cur_valid) push_line(blbl);
    @(posedge clk_i); #1;
    if (exp_q.size() > 0) begin
      int e = exp_q.pop_front();
      string l = lbl_q.pop_front();
      chk("R7", int'(stat_valid_o), 1);
      chk(l, int'(stat_data_o), e);
      cur_valid = 1;
    end else begin
      chk("R7", int'(stat_valid_o), 0);
      chk("R7", int'(stat_data_o), 0);
      cur_valid = 0;
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7FFFFF;
  endfunction

  task automatic idle(int n, string blbl);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, blbl);
  endtask

  initial begin
    foreach (cnt[b]) cnt[b] = 0;
    #(CLK_PERIOD*2 + 2);
    // R1
    chk("R1", int'(stat_valid_o), 0);
    chk("R1", int'(stat_data_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // frame 1: range boundaries and mixed codes
    phase = "R2 R3 R4 R6";
    frame_count_i = 16'h1234; frame_id_i = 16'hABCD;
    step(1, 0, 1, 0, "R6");
    begin
      int edges[12] = '{63, 64, 4095, 4096, 4607, 4608, 65535, 65536, 81919, 81920, 1048575, 2000};
      foreach (edges[i]) step(1, edges[i], 0, 0, "R2");
    end
    for (int i = 0; i < 300; i++) begin
      int r = rnd();
      int m = (r % 3 == 0) ? 'hFFF : (r % 3 == 1) ? 'hFFFF : 'hFFFFF;
      step(1, (r >> 2) & m, 0, 0, "R3");
    end
    phase = "R7";
    step(1, 1048575, 0, 1, "R4");

    // frame 2 accumulates while line 1 streams; ignored pulses and invalid pixels
    phase = "R12 R5";
    frame_count_i = 16'h0001; frame_id_i = 16'h00FF;
    step(1, 100, 1, 0, "R9");
    for (int i = 0; i < 200; i++) step(i % 2, 70000 + i * 37, 0, 0, "R9");
    phase = "R11";
    frame_count_i = 16'h5555;
    step(0, 0, 0, 1, "R11");
    for (int i = 0; i < 100; i++) step(0, 1000, 0, i == 50, "R11");
    phase = "R12 R5";
    for (int i = 0; i < 250; i++) step((i % 5) == 0, 5000 + i * 3, 0, 0, "R5");
    idle(10, "R5");
    step(0, 0, 0, 1, "R5");
    idle(500, "R5");

    // frame 3: saturation, and bins from frame 2 cleared
    phase = "R10 R6";
    frame_count_i = 16'hFE01; frame_id_i = 16'h0302;
    step(1, 5000, 1, 0, "R6");
    for (int i = 0; i < SAT + 60; i++) step(1, 5000, 0, 0, "R10");
    step(1, 300, 0, 1, "R6");
    idle(500, "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired (R7)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule